// File: doc/BRIEF.md
# Modal Accumulator Barrel Shifter

This block shifts an 8-bit accumulator left or right by zero to seven places. The shift distance comes from one of two places. In the immediate forms it is the 3-bit field at the bottom of the opcode. In the register forms that field selects a register, and the low three bits of that register's value give the distance. The caller decodes the register selection and supplies the value on `reg_val`. The result is combinational and appears on `acc_out` in the same cycle as the opcode. `acc_upd` tells the caller to write the result back.

Rotation and arithmetic fill are not encoded in the shift opcode. Two one-byte modifier instructions arm the next shift instead. One turns that shift into a rotate. The other makes it a right shift that fills with the sign bit. The block stores these pending modifiers. It clears them when the next shift executes, so they affect exactly one shift.

A shift opcode whose 3-bit field is zero has a different meaning. It is a reservation for one of four asynchronous readback channels. The block does not execute it. It raises `rsv_valid` with the channel number and passes the accumulator through unchanged.

Top module: `acc_shift_unit`

## Requirements
- R1: A valid opcode of the form 100d_sfff, with fff nonzero, is a shift. It asserts `acc_upd` in the same cycle. Bit 4 (d) set means a right shift. Bit 3 (s) set means the distance comes from the register.
- R2: With no modifier pending, a left shift moves the accumulator towards the MSB by the distance and fills with zeros. The immediate distance is fff.
- R3: With no modifier pending, a right shift moves the accumulator towards the LSB and fills with zeros.
- R4: In register form the distance is `reg_val[2:0]`, and the upper register bits are ignored. A distance of zero leaves the accumulator unchanged but still counts as a shift.
- R5: A valid opcode 0x04 arms rotate mode. The next shift, in either direction, becomes a rotate by the same distance.
- R6: A valid opcode 0x05 arms sign mode. The next right shift fills with the original bit 7. A left shift in sign mode is a plain logical shift.
- R7: Every executed shift clears both pending modifiers, including a shift by zero. The shift after it behaves as in R2/R3.
- R8: When both modifiers are pending, rotate wins.
- R9: A valid 100d_s000 opcode raises `rsv_valid`, with `rsv_chan` = {d,s} (0..3 for channels a..d). `acc_out` equals `acc_in`, `acc_upd` stays low, and pending modifiers are kept.
- R10: When `in_valid` is low, or when the opcode is any other value, `acc_out` equals `acc_in`, `acc_upd` and `rsv_valid` are low, and pending modifiers are unchanged.
- R11: Reset clears both pending modifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Opcode on `opcode` is issued this cycle |
| opcode | input | 8 | Instruction byte |
| reg_val | input | 8 | Value of the register selected by the opcode field |
| acc_in | input | 8 | Current accumulator |
| acc_out | output | 8 | Shifted accumulator, or `acc_in` when nothing executes |
| acc_upd | output | 1 | A shift executed; write `acc_out` back |
| rsv_valid | output | 1 | Readback reservation decoded |
| rsv_channel | output | 2 | Reserved channel, a=0 to d=3 |

## Verification
Some properties are checked on every cycle. A reservation never updates the accumulator and always passes it through. Rotates preserve the population count. A register-form shift by zero is an identity. Pending state is armed by a modifier and cleared after any shift, and it holds while no opcode is issued. The exact bit patterns need the bench's scenarios, which compare every output with a bit-serial model. Those are the logical, arithmetic and rotate results in each direction, rotate winning over sign, left shifts ignoring sign mode, and modifiers surviving reservations and reset clearing them.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  localparam int unsigned OPC_W   = 8;
  localparam int unsigned FIELD_W = 3;

  localparam logic [OPC_W-1:0] OPC_MOD_ROT = 8'h04;
  localparam logic [OPC_W-1:0] OPC_MOD_SGN = 8'h05;
  localparam logic [2:0]       SHIFT_TOP   = 3'b100;

  typedef enum logic [2:0] {
    K_NONE,
    K_SHIFT,
    K_RESERVE,
    K_MOD_ROT,
    K_MOD_SGN
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic               dir_right;
    logic               from_reg;
    logic [FIELD_W-1:0] field;
    logic [1:0]         chan;
  } dec_t;
endpackage

// File: rtl/acc_shift_rst_sync.sv
module acc_shift_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
  import acc_shift_pkg::*;
(
  input  logic             in_valid,
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  always_comb begin
    dec           = '0;
    dec.kind      = K_NONE;
    dec.dir_right = opcode[4];
    dec.from_reg  = opcode[3];
    dec.field     = opcode[FIELD_W-1:0];
    dec.chan      = opcode[4:3];
    if (in_valid) begin
      if (opcode[7:5] == SHIFT_TOP) begin
        if (opcode[FIELD_W-1:0] == '0) dec.kind = K_RESERVE;
        else                           dec.kind = K_SHIFT;
      end else if (opcode == OPC_MOD_ROT) begin
        dec.kind = K_MOD_ROT;
      end else if (opcode == OPC_MOD_SGN) begin
        dec.kind = K_MOD_SGN;
      end
    end
  end
endmodule

// File: rtl/acc_shift_mode.sv
module acc_shift_mode
  import acc_shift_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  kind_e kind,
  output logic rot_q,
  output logic sgn_q
);
  logic rot_d, sgn_d, mode_en;

  always_comb begin
    rot_d   = rot_q;
    sgn_d   = sgn_q;
    mode_en = 1'b0;
    unique case (kind)
      K_SHIFT:   begin rot_d = 1'b0; sgn_d = 1'b0; mode_en = 1'b1; end
      K_MOD_ROT: begin rot_d = 1'b1; mode_en = 1'b1; end
      K_MOD_SGN: begin sgn_d = 1'b1; mode_en = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q <= 1'b0;
      sgn_q <= 1'b0;
    end else if (mode_en) begin
      rot_q <= rot_d;
      sgn_q <= sgn_d;
    end
  end
endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core #(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              dir_right,
  input  logic              rotate,
  input  logic              sign_fill,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [AMT_W+1];
  logic              msb;

  assign stage[0] = din;
  assign msb      = din[DATA_W-1];
  assign dout     = stage[AMT_W];

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int unsigned D = 1 << i;
    logic [DATA_W-1:0] x, left_v, right_v;
    logic [D-1:0]      rfill;
    assign x = stage[i];

    always_comb begin
      if (rotate)         rfill = x[D-1:0];
      else if (sign_fill) rfill = {D{msb}};
      else                rfill = '0;
      right_v = {rfill, x[DATA_W-1:D]};
      left_v  = {x[DATA_W-D-1:0], (rotate ? x[DATA_W-1:DATA_W-D] : {D{1'b0}})};
    end

    assign stage[i+1] = !amt[i] ? x : (dir_right ? right_v : left_v);
  end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] acc_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              acc_upd,
  output logic              rsv_valid,
  output logic [1:0]        rsv_channel
);
  logic              rst_n_sync;
  dec_t              dec;
  logic              rot_q, sgn_q;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;

  acc_shift_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  acc_shift_decode u_dec (
    .in_valid(in_valid), .opcode(opcode), .dec(dec)
  );

  acc_shift_mode u_mode (
    .clk(clk), .rst_n(rst_n_sync), .kind(dec.kind),
    .rot_q(rot_q), .sgn_q(sgn_q)
  );

  assign amt = dec.from_reg ? reg_val[AMT_W-1:0] : AMT_W'(dec.field);

  acc_shift_core #(.DATA_W(DATA_W)) u_core (
    .din(acc_in), .amt(amt), .dir_right(dec.dir_right),
    .rotate(rot_q), .sign_fill(sgn_q & ~rot_q), .dout(shifted)
  );

  assign acc_upd     = (dec.kind == K_SHIFT);
  assign rsv_valid   = (dec.kind == K_RESERVE);
  assign rsv_channel = rsv_valid ? dec.chan : 2'b00;
  assign acc_out     = acc_upd ? shifted : acc_in;
endmodule

// File: rtl/acc_shift_checker.sv
module acc_shift_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] reg_val,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] acc_out,
  input logic              acc_upd,
  input logic              rsv_valid,
  input logic              rot_q,
  input logic              sgn_q
);
  AST_RSV_PASS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rsv_valid |-> (acc_out == acc_in) && !acc_upd); // R9
  AST_RSV_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rsv_valid |=> (rot_q == $past(rot_q)) && (sgn_q == $past(sgn_q))); // R9
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |-> (acc_out == acc_in) && !acc_upd && !rsv_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> $stable(rot_q) && $stable(sgn_q)); // R10
  AST_ROT_ARM: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && opcode == 8'h04) |=> rot_q); // R5
  AST_SGN_ARM: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && opcode == 8'h05) |=> sgn_q); // R6
  AST_SHIFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    acc_upd |=> !rot_q && !sgn_q); // R7
  AST_ZERO_DIST: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (acc_upd && opcode[3] && reg_val[2:0] == 3'd0) |-> acc_out == acc_in); // R4
  AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (acc_upd && rot_q) |-> $countones(acc_out) == $countones(acc_in)); // R8
endmodule

bind acc_shift_unit acc_shift_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .in_valid(in_valid), .opcode(opcode),
  .reg_val(reg_val), .acc_in(acc_in), .acc_out(acc_out), .acc_upd(acc_upd),
  .rsv_valid(rsv_valid), .rot_q(rot_q), .sgn_q(sgn_q)
);

// File: tb/sim_acc_shift_unit.sv
`timescale 1ns/1ps
module sim_acc_shift_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] opcode = 8'h00, reg_val = 8'h00, acc_in = 8'h00;
  logic [7:0] acc_out;
  logic       acc_upd, rsv_valid;
  logic [1:0] rsv_channel;

  int checks = 0, failures = 0;
  logic m_rot = 1'b0, m_sgn = 1'b0;

  always #4 clk = ~clk;

  acc_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .reg_val(reg_val), .acc_in(acc_in), .acc_out(acc_out), .acc_upd(acc_upd),
    .rsv_valid(rsv_valid), .rsv_channel(rsv_channel)
  );

  // returns {upd, rsv, chan[1:0], out[7:0]}
  function automatic logic [11:0] model(input logic v, input logic [7:0] op,
      input logic [7:0] a, input logic [7:0] r, input logic rp, input logic sp);
    logic [7:0] x = a;
    int n;
    if (!v || op[7:5] != 3'b100) return {4'b0000, a};
    if (op[2:0] == 3'd0) return {2'b01, op[4:3], a};
    n = op[3] ? int'(r[2:0]) : int'(op[2:0]);
    for (int k = 0; k < n; k++) begin
      if (op[4]) x = {(rp ? x[0] : (sp ? a[7] : 1'b0)), x[7:1]};
      else       x = {x[6:0], (rp ? x[7] : 1'b0)};
    end
    return {4'b1000, x};
  endfunction

  task automatic do_op(input logic v, input logic [7:0] op, input logic [7:0] a,
                       input logic [7:0] r, input string req);
    logic [11:0] exp_v, got;
    @(negedge clk);
    in_valid = v; opcode = op; acc_in = a; reg_val = r;
    #2;
    exp_v = model(v, op, a, r, m_rot, m_sgn);
    got   = {acc_upd, rsv_valid, rsv_channel, acc_out};
    checks++;
    if (got !== exp_v) begin
      failures++;
      $display("FAIL %s op=%h acc=%h reg=%h actual=%h expected=%h", req, op, a, r, got, exp_v);
    end
    if (v && exp_v[11]) begin m_rot = 1'b0; m_sgn = 1'b0; end
    else if (v && op == 8'h04) m_rot = 1'b1;
    else if (v && op == 8'h05) m_sgn = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    m_rot = 1'b0; m_sgn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] op;
    int sel;
    void'($urandom(32'd4242));
    do_reset();
    do_op(1'b0, 8'h91, 8'hA5, 8'h00, "R11");  // idle after reset
    do_op(1'b1, 8'h81, 8'h0F, 8'h00, "R2");
    do_op(1'b1, 8'h87, 8'h03, 8'h00, "R2");
    do_op(1'b1, 8'h92, 8'hF0, 8'h00, "R3");
    do_op(1'b1, 8'h89, 8'h11, 8'hFA, "R4");
    do_op(1'b1, 8'h9B, 8'h11, 8'hFD, "R1");
    do_op(1'b1, 8'h04, 8'h00, 8'h00, "R5");
    do_op(1'b1, 8'h91, 8'h81, 8'h00, "R5");
    do_op(1'b1, 8'h91, 8'h81, 8'h00, "R7");
    do_op(1'b1, 8'h04, 8'h00, 8'h00, "R5");
    do_op(1'b1, 8'h83, 8'hE1, 8'h00, "R5");
    do_op(1'b1, 8'h05, 8'h00, 8'h00, "R6");
    do_op(1'b1, 8'h92, 8'h80, 8'h00, "R6");
    do_op(1'b1, 8'h05, 8'h00, 8'h00, "R6");
    do_op(1'b1, 8'h82, 8'h81, 8'h00, "R6");
    do_op(1'b1, 8'h04, 8'h00, 8'h00, "R8");
    do_op(1'b1, 8'h05, 8'h00, 8'h00, "R8");
    do_op(1'b1, 8'h91, 8'h01, 8'h00, "R8");
    do_op(1'b1, 8'h91, 8'h01, 8'h00, "R7");
    do_op(1'b1, 8'h04, 8'h00, 8'h00, "R7");
    do_op(1'b1, 8'h99, 8'h5A, 8'h08, "R7");
    do_op(1'b1, 8'h91, 8'h01, 8'h00, "R7");
    do_op(1'b1, 8'h04, 8'h00, 8'h00, "R9");
    do_op(1'b1, 8'h90, 8'h3C, 8'h00, "R9");
    do_op(1'b1, 8'h88, 8'h3C, 8'h00, "R9");
    do_op(1'b1, 8'h91, 8'h01, 8'h00, "R9");
    do_op(1'b1, 8'h04, 8'h00, 8'h00, "R10");
    do_op(1'b0, 8'h05, 8'h00, 8'h00, "R10");
    do_op(1'b1, 8'h06, 8'h77, 8'h00, "R10");
    do_op(1'b1, 8'hA3, 8'h77, 8'h00, "R10");
    do_op(1'b1, 8'h92, 8'h80, 8'h00, "R10");
    do_op(1'b1, 8'h05, 8'h00, 8'h00, "R11");
    do_op(1'b1, 8'h04, 8'h00, 8'h00, "R11");
    do_reset();
    do_op(1'b1, 8'h92, 8'h80, 8'h00, "R11");

    for (int i = 0; i < 4000; i++) begin
      sel = int'($urandom_range(0, 9));
      op  = 8'($urandom);
      if (sel < 5)       op[7:5] = 3'b100;
      else if (sel == 5) op = 8'h04;
      else if (sel == 6) op = 8'h05;
      do_op(($urandom_range(0, 7) != 0), op, 8'($urandom), 8'($urandom),
            (m_rot ? "R5" : (m_sgn ? "R6" : "R1")));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule